// File: doc/BRIEF.md
# Serial Flash Status Register and Write Guard

This block keeps the status byte of a serial flash device and decides whether a requested change to the array or to the status byte itself may go ahead. A command decoder hands it single-cycle pulses for set-write-enable, clear-write-enable and status-write. A status-write pulse comes with the byte shifted in and is issued in the cycle the chip select goes high. The block also sees the level of the active-low write-protect pin, the engine's busy flag and a completion pulse from the program/erase engine.

From the block-protect field, the top/bottom select and the address that the decoder presents, the block produces a protect-hit flag. It also produces three permission flags: program allowed, erase allowed and status-write allowed. The lock bit works with the write-protect pin to freeze the protection settings. The write-enable latch must be set before any change is allowed, and it clears itself once a change has been accepted.

Top module: `fsr_ctrl`

## Requirements
- R1: After reset the status byte reads 00h, so nothing is protected and the write-enable latch is clear.
- R2: The status byte layout is as follows. Bit 0 shows `busy_in` in the same cycle, with no register. Bit 1 is the write-enable latch, bits 4:2 are the protect field BP, bit 5 is TB, bit 6 always reads 0 and bit 7 is the lock bit. The byte is valid in every cycle, including while busy.
- R3: `cmd_wren` sets the write-enable latch from the next cycle. `cmd_wrdi` clears it. If `cmd_wren` comes in the same cycle as any clearing event, the latch ends up set.
- R4: An `op_done` pulse clears the write-enable latch.
- R5: While the latch is clear or `busy_in` is 1, `prog_ok`, `erase_ok` and `wrsr_ok` are 0. A `cmd_wrsr` pulse in that state changes nothing in the status byte.
- R6: An accepted status write loads BP from `wr_data[4:2]`, TB from `wr_data[5]` and the lock bit from `wr_data[7]`. It ignores `wr_data[1:0]` and `wr_data[6]`, and it clears the write-enable latch.
- R7: `wp_n` is sampled in the cycle of `cmd_wrsr`. If `wp_n` is 0 and the lock bit is 1, an accepted status write keeps BP, TB and the lock bit unchanged and still clears the latch. If `wp_n` is 1, every writable bit can change, including clearing the lock bit.
- R8: The block number is `req_addr[18:16]`, giving eight 64 KB blocks. The number of protected blocks is 0 when BP=0, 2^(BP-1) when BP is 1 to 3, and all 8 when BP is 4 to 7. With TB=0 the protected blocks are the highest-numbered ones; with TB=1 they start at block 0.
- R9: When `req_chip` is 1 (a whole-array erase), `protect_hit` is 1 exactly when BP is not 0. Otherwise `protect_hit` is 1 exactly when the block of `req_addr` is protected.
- R10: `prog_ok` is 1 exactly when the latch is set, `busy_in` is 0 and the block of `req_addr` is not protected. `erase_ok` follows the same rule but uses `protect_hit`. `wrsr_ok` is 1 exactly when the latch is set and `busy_in` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_wren | input | 1 | Set-write-enable command pulse |
| cmd_wrdi | input | 1 | Clear-write-enable command pulse |
| cmd_wrsr | input | 1 | Status-write pulse, issued when chip select rises |
| wr_data | input | 8 | Status byte received with the status write |
| wp_n | input | 1 | Write-protect pin level, active low |
| busy_in | input | 1 | Program/erase engine busy |
| op_done | input | 1 | Program/erase completion pulse |
| req_addr | input | 19 | Target address of a program or erase |
| req_chip | input | 1 | Request is a whole-array erase |
| status | output | 8 | Status byte |
| prog_ok | output | 1 | Program permitted at `req_addr` |
| erase_ok | output | 1 | Erase permitted for the request |
| wrsr_ok | output | 1 | Status write permitted |
| protect_hit | output | 1 | Request falls in the protected region |

## Verification
Two events can arrive in the same cycle: the completion pulse from the engine, which clears the write-enable latch, and a new set-write-enable command from the decoder. The bench raises `op_done` and `cmd_wren` together and expects the latch to read 1 on the next cycle; it then raises `op_done` alone and expects 0. The bench also sweeps all sixteen protect and TB settings against all eight blocks and against a whole-array erase. It compares the hit and permission flags with a block count that it computes arithmetically.

// File: rtl/fsr_pkg.sv
package fsr_pkg;
    localparam int ST_BUSY = 0;
    localparam int ST_WEL  = 1;
    localparam int ST_BP   = 2;
    localparam int ST_TB   = 5;
    localparam int ST_LOCK = 7;

    typedef struct packed {
        logic       lock;
        logic       tb;
        logic [2:0] bp;
    } prot_cfg_t;
endpackage

// File: rtl/fsr_wel_latch.sv
module fsr_wel_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic wel_o
);
    typedef struct packed {
        logic wel;
    } wel_st_t;

    wel_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_i) st_d.wel = 1'b0;
        if (set_i) st_d.wel = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign wel_o = st_q.wel;
endmodule

// File: rtl/fsr_prot_bits.sv
module fsr_prot_bits
    import fsr_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      wr_i,
    input  prot_cfg_t wr_cfg_i,
    input  logic      wp_n_i,
    output prot_cfg_t cfg_o
);
    prot_cfg_t cfg_d, cfg_q;
    logic      frozen;

    always_comb begin
        frozen = cfg_q.lock & ~wp_n_i;
        cfg_d  = cfg_q;
        if (wr_i && !frozen) cfg_d = wr_cfg_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign cfg_o = cfg_q;
endmodule

// File: rtl/fsr_prot_decode.sv
module fsr_prot_decode
    import fsr_pkg::*;
#(
    parameter int BLK_LOG2 = 3,
    parameter int BLK_W    = 16
) (
    input  prot_cfg_t                  cfg_i,
    input  logic [BLK_LOG2+BLK_W-1:0]  addr_i,
    input  logic                       chip_i,
    output logic                       addr_hit_o,
    output logic                       hit_o
);
    localparam int NBLK   = 1 << BLK_LOG2;
    localparam int ADDR_W = BLK_LOG2 + BLK_W;

    int                  cnt;
    logic [NBLK-1:0]     mask;
    logic [BLK_LOG2-1:0] blk;

    always_comb begin
        if (cfg_i.bp == 3'd0)                    cnt = 0;
        else if (int'(cfg_i.bp) - 1 >= BLK_LOG2) cnt = NBLK;
        else                                     cnt = 1 << (int'(cfg_i.bp) - 1);
    end

    for (genvar i = 0; i < NBLK; i++) begin : g_blk
        assign mask[i] = cfg_i.tb ? (i < cnt) : (i + cnt >= NBLK);
    end

    assign blk        = addr_i[ADDR_W-1:BLK_W];
    assign addr_hit_o = mask[blk];
    assign hit_o      = chip_i ? (|mask) : addr_hit_o;
endmodule

// File: rtl/fsr_ctrl.sv
module fsr_ctrl
    import fsr_pkg::*;
#(
    parameter int BLK_LOG2 = 3,
    parameter int BLK_W    = 16,
    localparam int ADDR_W  = BLK_LOG2 + BLK_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_wren,
    input  logic              cmd_wrdi,
    input  logic              cmd_wrsr,
    input  logic [7:0]        wr_data,
    input  logic              wp_n,
    input  logic              busy_in,
    input  logic              op_done,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_chip,
    output logic [7:0]        status,
    output logic              prog_ok,
    output logic              erase_ok,
    output logic              wrsr_ok,
    output logic              protect_hit
);
    logic      wel;
    logic      wrsr_acc;
    logic      addr_hit;
    logic      may_write;
    prot_cfg_t cfg;
    prot_cfg_t wr_cfg;

    assign may_write = wel & ~busy_in;
    assign wrsr_acc  = cmd_wrsr & may_write;

    always_comb begin
        wr_cfg.bp   = wr_data[ST_BP+2:ST_BP];
        wr_cfg.tb   = wr_data[ST_TB];
        wr_cfg.lock = wr_data[ST_LOCK];
    end

    fsr_wel_latch u_wel (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (cmd_wren),
        .clr_i (cmd_wrdi | op_done | wrsr_acc),
        .wel_o (wel)
    );

    fsr_prot_bits u_bits (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_i     (wrsr_acc),
        .wr_cfg_i (wr_cfg),
        .wp_n_i   (wp_n),
        .cfg_o    (cfg)
    );

    fsr_prot_decode #(.BLK_LOG2(BLK_LOG2), .BLK_W(BLK_W)) u_dec (
        .cfg_i      (cfg),
        .addr_i     (req_addr),
        .chip_i     (req_chip),
        .addr_hit_o (addr_hit),
        .hit_o      (protect_hit)
    );

    always_comb begin
        status                   = '0;
        status[ST_BUSY]          = busy_in;
        status[ST_WEL]           = wel;
        status[ST_BP+2:ST_BP]    = cfg.bp;
        status[ST_TB]            = cfg.tb;
        status[ST_LOCK]          = cfg.lock;
    end

    assign prog_ok  = may_write & ~addr_hit;
    assign erase_ok = may_write & ~protect_hit;
    assign wrsr_ok  = may_write;
endmodule

// File: rtl/fsr_ctrl_chk.sv
module fsr_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cmd_wren,
    input logic       cmd_wrdi,
    input logic       cmd_wrsr,
    input logic       wp_n,
    input logic       busy_in,
    input logic       op_done,
    input logic       req_chip,
    input logic [7:0] status,
    input logic       prog_ok,
    input logic       erase_ok,
    input logic       wrsr_ok,
    input logic       protect_hit
);
    a_r3_wren_sets: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_wren |=> status[1]);

    a_r3_wrdi_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wrdi && !cmd_wren) |=> !status[1]);

    a_r4_done_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (op_done && !cmd_wren) |=> !status[1]);

    a_r5_refused_wrsr: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wrsr && (!status[1] || busy_in)) |=> $stable(status[7:2]));

    a_r5_no_wel_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (!status[1] || busy_in) |-> (!prog_ok && !erase_ok && !wrsr_ok));

    a_r6_wrsr_clears_wel: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wrsr && wrsr_ok && !cmd_wren) |=> !status[1]);

    a_r2_bit6_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !status[6]);

    a_r7_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wrsr && status[7] && !wp_n) |=> (status[7] && $stable(status[5:2])));

    a_r9_hit_blocks_erase: assert property (@(posedge clk) disable iff (!rst_n)
        protect_hit |-> !erase_ok);

    a_r9_chip_no_bp: assert property (@(posedge clk) disable iff (!rst_n)
        (req_chip && status[4:2] == 3'd0) |-> !protect_hit);

    a_r10_prog_needs_free: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_chip && protect_hit) |-> !prog_ok);
endmodule

bind fsr_ctrl fsr_ctrl_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_wren    (cmd_wren),
    .cmd_wrdi    (cmd_wrdi),
    .cmd_wrsr    (cmd_wrsr),
    .wp_n        (wp_n),
    .busy_in     (busy_in),
    .op_done     (op_done),
    .req_chip    (req_chip),
    .status      (status),
    .prog_ok     (prog_ok),
    .erase_ok    (erase_ok),
    .wrsr_ok     (wrsr_ok),
    .protect_hit (protect_hit)
);

// File: tb/sim_fsr_ctrl.sv
module sim_fsr_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_wren = 1'b0, cmd_wrdi = 1'b0, cmd_wrsr = 1'b0;
    logic [7:0]  wr_data = '0;
    logic        wp_n = 1'b1, busy_in = 1'b0, op_done = 1'b0;
    logic [18:0] req_addr = '0;
    logic        req_chip = 1'b0;
    logic [7:0]  status;
    logic        prog_ok, erase_ok, wrsr_ok, protect_hit;

    int n_run = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    fsr_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .cmd_wren(cmd_wren), .cmd_wrdi(cmd_wrdi),
        .cmd_wrsr(cmd_wrsr), .wr_data(wr_data), .wp_n(wp_n), .busy_in(busy_in),
        .op_done(op_done), .req_addr(req_addr), .req_chip(req_chip),
        .status(status), .prog_ok(prog_ok), .erase_ok(erase_ok),
        .wrsr_ok(wrsr_ok), .protect_hit(protect_hit)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        cmd_wren = 1'b0; cmd_wrdi = 1'b0; cmd_wrsr = 1'b0; op_done = 1'b0;
        #1;
    endtask

    task automatic do_wren(); cmd_wren = 1'b1; tick(); endtask

    task automatic do_wrsr(input logic [7:0] d);
        wr_data = d; cmd_wrsr = 1'b1; tick();
    endtask

    function automatic int prot_cnt(input int bp);
        if (bp == 0) return 0;
        if (bp >= 4) return 8;
        return 1 << (bp - 1);
    endfunction

    initial begin
        #2000000;
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: got 0 expected 1");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R1 reset status", status, 8'h00);
        check("R5 prog_ok without latch", {7'd0, prog_ok}, 8'd0);

        do_wren();
        check("R3 wren sets latch", status, 8'h02);
        check("R10 wrsr_ok with latch", {7'd0, wrsr_ok}, 8'd1);
        cmd_wrdi = 1'b1; tick();
        check("R3 wrdi clears latch", status, 8'h00);

        do_wren();
        busy_in = 1'b1; #1;
        check("R2 busy bit same cycle", status, 8'h03);
        check("R5 wrsr_ok while busy", {7'd0, wrsr_ok}, 8'd0);
        check("R5 prog_ok while busy", {7'd0, prog_ok}, 8'd0);
        do_wrsr(8'hBC);
        check("R5 wrsr refused while busy", status, 8'h03);
        op_done = 1'b1; cmd_wren = 1'b1; tick();
        check("R3 wren beats op_done", status, 8'h03);
        op_done = 1'b1; tick();
        check("R4 op_done clears latch", status, 8'h01);
        busy_in = 1'b0; #1;

        do_wrsr(8'hBC);
        check("R5 wrsr without latch ignored", status, 8'h00);

        wp_n = 1'b1;
        do_wren();
        do_wrsr(8'hFF);
        check("R6 wrsr loads, ignores 0,1,6, clears latch", status, 8'hBC);

        wp_n = 1'b0;
        do_wren();
        do_wrsr(8'h00);
        check("R7 locked bits frozen", status, 8'hBC);
        do_wren();
        check("R7 latch set before locked write", status, 8'hBE);
        do_wrsr(8'h14);
        check("R7 locked write keeps bits, clears latch", status, 8'hBC);

        wp_n = 1'b1;
        do_wren();
        do_wrsr(8'h00);
        check("R7 pin high unlocks", status, 8'h00);

        wp_n = 1'b0;
        do_wren();
        do_wrsr(8'h88);
        check("R7 lock set while pin low", status, 8'h88);
        wp_n = 1'b1;

        for (int tb = 0; tb < 2; tb++) begin
            for (int bp = 0; bp < 8; bp++) begin
                logic [7:0] want;
                int cnt;
                want = {2'b00, tb[0], bp[2:0], 2'b00};
                cnt = prot_cnt(bp);
                do_wren();
                do_wrsr(want);
                check("R6 sweep status", status, want);
                do_wren();
                for (int blk = 0; blk < 8; blk++) begin
                    logic hit;
                    hit = (tb == 1) ? (blk < cnt) : (blk >= 8 - cnt);
                    req_chip = 1'b0;
                    req_addr = 19'((blk << 16) | (16'h1234 + blk));
                    #1;
                    check($sformatf("R8 hit tb%0d bp%0d blk%0d", tb, bp, blk),
                          {7'd0, protect_hit}, {7'd0, hit});
                    check($sformatf("R10 prog_ok tb%0d bp%0d blk%0d", tb, bp, blk),
                          {6'd0, prog_ok, erase_ok}, {6'd0, !hit, !hit});
                end
                req_chip = 1'b1; #1;
                check($sformatf("R9 chip hit tb%0d bp%0d", tb, bp),
                      {7'd0, protect_hit}, {7'd0, bp != 0});
                check($sformatf("R9 chip erase_ok tb%0d bp%0d", tb, bp),
                      {7'd0, erase_ok}, {7'd0, bp == 0});
                req_chip = 1'b0;
                cmd_wrdi = 1'b1; tick();
            end
        end

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule